// File: doc/BRIEF.md
# Rational M/D Clock-Enable Synthesizer

This block turns a stream of input-cycle event strobes into a synthesized clock pattern whose average frequency is the input event rate times M divided by D. It runs entirely in one fast reference clock domain. A phase accumulator gains 2·M on every input event and drains by D once per reference cycle, toggling the synthesized output each time it does. The result is a 50% duty pattern together with its complement, a rising-edge enable pulse, and an alignment pulse that marks where the input and output cycle sequences meet again.

The ratio is reduced to lowest terms internally. The realignment period is therefore D/g input events, which is M/g output periods, where g is the greatest common divisor of M and D. A synchronous start loads the ratio and clears all state. A ratio presented later is adopted only at an alignment point, once the accumulator has drained to zero. No feedback input is needed. Input events must be at least 2·MUL_MAX reference cycles apart so that each burst of toggles completes before the next event arrives.

Top module: `ratio_tick_synth`

## Requirements
- R1: With a valid ratio and input events spaced per the usage rule, the number of `fx_o` toggles after N events and full drain is floor(2·M·N/D). `fx_o` starts at 0.
- R2: A multiply value outside 2..32 inclusive drives `cfg_bad_o` high in the same cycle. A start with such a value leaves the block idle, with no toggles and no alignment pulses.
- R3: A divide value outside 1..32 inclusive (including 0 and 33) drives `cfg_bad_o` high in the same cycle. A start with such a value leaves the block idle.
- R4: `align_o` is a one-cycle pulse in the cycle after the clock edge that captures every (D/g)-th input event since start, where g = gcd(M, D).
- R5: `fx_n_o` is always the inverse of `fx_o`.
- R6: `rise_o` pulses for exactly one cycle in the cycle where `fx_o` has just changed from 0 to 1.
- R7: A ratio applied on `mul_i`/`div_i` after start takes effect only at the first alignment point where the accumulator is empty. An invalid ratio seen at that point is discarded and the old ratio is kept.
- R8: `rst_ni` low, or `start_i` high at a clock edge, clears the accumulator, the event counter and the outputs (`fx_o`=0, `fx_n_o`=1, `rise_o`=0, `align_o`=0).
- R9: Between two consecutive ratio adoption points, the synthesized output toggles exactly 2·M times, where M is the reduced multiply value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous start: clears state and loads the ratio |
| mul_i | input | RW | Multiply value M |
| div_i | input | RW | Divide value D |
| in_evt_i | input | 1 | One-cycle strobe per input clock cycle |
| fx_o | output | 1 | Synthesized clock level |
| fx_n_o | output | 1 | Complement of the synthesized clock |
| rise_o | output | 1 | Pulse on each rising edge of `fx_o` |
| align_o | output | 1 | Pulse at each input/output realignment |
| cfg_bad_o | output | 1 | Current ratio inputs are out of range |

## Verification
`cfg_bad_o` is combinational, so it is checked in the same cycle the ratio inputs change. `fx_o`, `fx_n_o` and `rise_o` first change after the edge that captures an event, and then keep toggling for up to 2·M cycles while the accumulator drains. The bench therefore samples on every falling edge, counts changes, and compares totals only after an 80-cycle gap per event. `align_o` is due one cycle after the capturing edge. The directed test samples it at the first falling edge after that edge and again one cycle later to confirm it is a single-cycle pulse.

// File: rtl/rsyn_pkg.sv
package rsyn_pkg;

   // Euclid on small integers; a fixed trip count covers operands up to 2**16
   function automatic int rs_gcd(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      for (int i = 0; i < 24; i++) begin
         if (y != 0) begin
            t = x % y;
            x = y;
            y = t;
         end
      end
      return x;
   endfunction

endpackage

// File: rtl/rsyn_ratio.sv
module rsyn_ratio
   import rsyn_pkg::*;
#(
   parameter int RW        = 6,
   parameter int MUL_MIN   = 2,
   parameter int MUL_MAX   = 32,
   parameter int DIV_MIN   = 1,
   parameter int DIV_MAX   = 32,
   parameter bit REDUCE_EN = 1'b1
) (
   input  logic [RW-1:0] mul_i,
   input  logic [RW-1:0] div_i,
   output logic          ok_o,
   output logic [RW-1:0] m_o,
   output logic [RW-1:0] d_o
);

   always_comb begin
      ok_o = (mul_i >= RW'(MUL_MIN)) && (mul_i <= RW'(MUL_MAX)) &&
             (div_i >= RW'(DIV_MIN)) && (div_i <= RW'(DIV_MAX));
   end

   generate
      if (REDUCE_EN) begin : g_reduce
         int g_w;
         always_comb begin
            g_w = rs_gcd(int'(mul_i), int'(div_i));
            if (g_w < 1) g_w = 1;
            m_o = RW'(int'(mul_i) / g_w);
            d_o = RW'(int'(div_i) / g_w);
         end
      end else begin : g_pass
         assign m_o = mul_i;
         assign d_o = div_i;
      end
   endgenerate

endmodule

// File: rtl/rsyn_phase_acc.sv
module rsyn_phase_acc #(
   parameter int RW      = 6,
   parameter int MUL_MAX = 32,
   parameter int DIV_MAX = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          run_i,
   input  logic          evt_i,
   input  logic [RW-1:0] m_i,
   input  logic [RW-1:0] d_i,
   output logic          fx_o,
   output logic          fx_n_o,
   output logic          rise_o,
   output logic          tog_o,
   output logic          drained_o
);

   localparam int ACC_LIM = 2 * MUL_MAX + DIV_MAX;
   localparam int ACC_W   = $clog2(ACC_LIM + 1);

   logic [ACC_W-1:0] acc_q, acc_d, sum_w, add_w, d_ext;
   logic             fx_q, fx_n_q, rise_q, tog_w;

   always_comb begin
      add_w = (evt_i && run_i) ? (ACC_W'(m_i) << 1) : '0;
      d_ext = ACC_W'(d_i);
      sum_w = acc_q + add_w;
      if (run_i && (sum_w >= d_ext)) begin
         tog_w = 1'b1;
         acc_d = sum_w - d_ext;
      end else begin
         tog_w = 1'b0;
         acc_d = sum_w;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q  <= '0;
         fx_q   <= 1'b0;
         fx_n_q <= 1'b1;
         rise_q <= 1'b0;
      end else if (clr_i) begin
         acc_q  <= '0;
         fx_q   <= 1'b0;
         fx_n_q <= 1'b1;
         rise_q <= 1'b0;
      end else begin
         acc_q  <= acc_d;
         fx_q   <= fx_q ^ tog_w;
         fx_n_q <= ~(fx_q ^ tog_w);
         rise_q <= tog_w & ~fx_q;
      end
   end

   assign fx_o      = fx_q;
   assign fx_n_o    = fx_n_q;
   assign rise_o    = rise_q;
   assign tog_o     = tog_w;
   assign drained_o = (acc_d == '0);

   // R1
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_q < ACC_W'(ACC_LIM));

   // R5
   compl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fx_n_q == !fx_q);

   // R6
   rise_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_q |-> (fx_q && !$past(fx_q)));

endmodule

// File: rtl/rsyn_align.sv
module rsyn_align #(
   parameter int RW = 6
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   input  logic          evt_i,
   input  logic [RW-1:0] d_i,
   output logic          wrap_o,
   output logic          align_o
);

   logic [RW-1:0] cnt_q;
   logic          align_q;
   logic          wrap_w;

   assign wrap_w = evt_i && ((cnt_q + RW'(1)) == d_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         align_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q   <= '0;
         align_q <= 1'b0;
      end else begin
         align_q <= wrap_w;
         if (evt_i) cnt_q <= wrap_w ? '0 : cnt_q + RW'(1);
      end
   end

   assign wrap_o  = wrap_w;
   assign align_o = align_q;

   // R4
   align_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      align_q |-> (cnt_q == '0));

   // R4
   align_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !evt_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ratio_tick_synth.sv
module ratio_tick_synth #(
   parameter int RW        = 6,
   parameter int MUL_MIN   = 2,
   parameter int MUL_MAX   = 32,
   parameter int DIV_MIN   = 1,
   parameter int DIV_MAX   = 32,
   parameter bit REDUCE_EN = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [RW-1:0] mul_i,
   input  logic [RW-1:0] div_i,
   input  logic          in_evt_i,
   output logic          fx_o,
   output logic          fx_n_o,
   output logic          rise_o,
   output logic          align_o,
   output logic          cfg_bad_o
);

   localparam int TOG_W = $clog2(2 * MUL_MAX + 2);

   generate
      if (MUL_MAX >= (1 << RW) || DIV_MAX >= (1 << RW)) begin : g_bad_rw
         $error("ratio width too small for limits");
      end
      if (MUL_MIN < 1 || DIV_MIN < 1 || MUL_MIN > MUL_MAX || DIV_MIN > DIV_MAX) begin : g_bad_lim
         $error("ratio limits inconsistent");
      end
   endgenerate

   logic          ok_w;
   logic [RW-1:0] m_red_w, d_red_w;
   logic [RW-1:0] m_act_q, d_act_q;
   logic          run_q, pend_q;
   logic          evt_w, tog_w, drained_w, wrap_w, swap_w;
   logic [TOG_W-1:0] tog_cnt_q;

   rsyn_ratio #(
      .RW(RW), .MUL_MIN(MUL_MIN), .MUL_MAX(MUL_MAX),
      .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .REDUCE_EN(REDUCE_EN)
   ) u_ratio (
      .mul_i(mul_i), .div_i(div_i),
      .ok_o(ok_w), .m_o(m_red_w), .d_o(d_red_w)
   );

   assign evt_w  = in_evt_i & run_q & ~start_i;
   assign swap_w = run_q & ~start_i & (pend_q | wrap_w) & drained_w;

   rsyn_phase_acc #(
      .RW(RW), .MUL_MAX(MUL_MAX), .DIV_MAX(DIV_MAX)
   ) u_acc (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i), .run_i(run_q),
      .evt_i(evt_w), .m_i(m_act_q), .d_i(d_act_q),
      .fx_o(fx_o), .fx_n_o(fx_n_o), .rise_o(rise_o),
      .tog_o(tog_w), .drained_o(drained_w)
   );

   rsyn_align #(.RW(RW)) u_align (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(start_i), .evt_i(evt_w),
      .d_i(d_act_q), .wrap_o(wrap_w), .align_o(align_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         m_act_q <= RW'(1);
         d_act_q <= RW'(1);
         run_q   <= 1'b0;
         pend_q  <= 1'b0;
      end else if (start_i) begin
         run_q  <= ok_w;
         pend_q <= 1'b0;
         if (ok_w) begin
            m_act_q <= m_red_w;
            d_act_q <= d_red_w;
         end
      end else if (swap_w) begin
         pend_q <= 1'b0;
         if (ok_w) begin
            m_act_q <= m_red_w;
            d_act_q <= d_red_w;
         end
      end else if (wrap_w) begin
         pend_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 tog_cnt_q <= '0;
      else if (start_i || swap_w)  tog_cnt_q <= '0;
      else if (tog_w)              tog_cnt_q <= tog_cnt_q + TOG_W'(1);
   end

   assign cfg_bad_o = ~ok_w;

   // R9
   period_tog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      swap_w |-> ((tog_cnt_q + TOG_W'(tog_w)) == (TOG_W'(m_act_q) << 1)));

   // R7
   cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(swap_w || start_i) |=> ($stable(m_act_q) && $stable(d_act_q)));

   // R2
   act_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |-> ((m_act_q >= RW'(1)) && (d_act_q >= RW'(1)) && (d_act_q <= RW'(DIV_MAX))));

   // R8
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q |=> (!rise_o && !align_o));

endmodule

// File: tb/ratio_tick_synth_tb.sv
module ratio_tick_synth_tb;

   localparam int RW  = 6;
   localparam int GAP = 80;
   localparam int NV  = 11;

   // columns: multiply, divide, events, expected toggles, expected aligns, expected bad flag
   localparam int V_MUL [NV] = '{2, 3, 4, 32, 5, 32, 7, 1, 40, 3, 9};
   localparam int V_DIV [NV] = '{1, 2, 6, 32, 7, 1, 3, 4, 2, 0, 33};
   localparam int V_NEV [NV] = '{3, 4, 6, 5, 7, 2, 4, 3, 2, 2, 2};
   localparam int V_TOG [NV] = '{12, 12, 8, 10, 10, 128, 18, 0, 0, 0, 0};
   localparam int V_AL  [NV] = '{3, 2, 2, 5, 1, 2, 1, 0, 0, 0, 0};
   localparam int V_BAD [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic evt = 1'b0;
   logic [RW-1:0] mul = '0;
   logic [RW-1:0] dv = '0;
   logic fx, fx_n, rise, align, bad;

   int checks = 0;
   int fails = 0;
   int tog_n, rise_n, al_n, compl_err;
   logic fx_prev;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ratio_tick_synth #(.RW(RW)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mul_i(mul), .div_i(dv),
      .in_evt_i(evt), .fx_o(fx), .fx_n_o(fx_n), .rise_o(rise),
      .align_o(align), .cfg_bad_o(bad)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      if (fx !== fx_prev) tog_n++;
      if (rise) rise_n++;
      if (align) al_n++;
      if (fx_n !== ~fx) compl_err++;
      fx_prev = fx;
   endtask

   task automatic clear_counts();
      tog_n = 0; rise_n = 0; al_n = 0; compl_err = 0;
      fx_prev = fx;
   endtask

   task automatic do_start(input int m, input int d);
      mul = RW'(m); dv = RW'(d);
      start = 1'b1;
      step();
      start = 1'b0;
      clear_counts();
   endtask

   task automatic one_event();
      evt = 1'b1;
      step();
      evt = 1'b0;
      for (int k = 0; k < GAP - 1; k++) step();
   endtask

   initial begin
      clear_counts();
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(fx == 1'b0 && fx_n == 1'b1, "R8 reset fx/fx_n", int'(fx), 0);
      chk(rise == 1'b0 && align == 1'b0, "R8 reset pulses", int'(rise) + int'(align), 0);
      rst_n = 1'b1;
      step();

      // table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         mul = RW'(V_MUL[v]); dv = RW'(V_DIV[v]);
         #1;
         chk(int'(bad) == V_BAD[v], "R2/R3 cfg_bad", int'(bad), V_BAD[v]);
         do_start(V_MUL[v], V_DIV[v]);
         chk(fx == 1'b0, "R8 start clears fx", int'(fx), 0);
         for (int e = 0; e < V_NEV[v]; e++) one_event();
         chk(tog_n == V_TOG[v], "R1 toggle count", tog_n, V_TOG[v]);
         chk(al_n == V_AL[v], "R4 align count", al_n, V_AL[v]);
         chk(rise_n == (V_TOG[v] + 1) / 2, "R6 rise count", rise_n, (V_TOG[v] + 1) / 2);
         chk(compl_err == 0, "R5 complement", compl_err, 0);
      end

      // R4 align timing: reduced 5/2 aligns every 2nd event
      do_start(5, 2);
      evt = 1'b1; step(); evt = 1'b0;
      chk(align == 1'b0, "R4 no align on first event", int'(align), 0);
      for (int k = 0; k < GAP - 1; k++) step();
      evt = 1'b1; step(); evt = 1'b0;
      chk(align == 1'b1, "R4 align after second event", int'(align), 1);
      step();
      chk(align == 1'b0, "R4 align single cycle", int'(align), 0);
      for (int k = 0; k < GAP; k++) step();

      // R7 ratio change deferred to alignment: start 3/4, switch inputs to 2/1
      do_start(3, 4);
      one_event();
      mul = RW'(2); dv = RW'(1);
      one_event(); one_event(); one_event();
      chk(tog_n == 6, "R7 old ratio until alignment", tog_n, 6);
      one_event();
      chk(tog_n == 10, "R7 new ratio after alignment", tog_n, 10);
      // R7 invalid ratio at alignment is discarded
      mul = RW'(1); dv = RW'(1);
      one_event(); one_event();
      chk(tog_n == 18, "R7 invalid ratio ignored", tog_n, 18);

      // R8 start mid-run clears outputs
      do_start(2, 1);
      evt = 1'b1; step(); evt = 1'b0;
      start = 1'b1; step(); start = 1'b0;
      chk(fx == 1'b0 && fx_n == 1'b1, "R8 start clears outputs", int'(fx), 0);
      clear_counts();
      for (int k = 0; k < GAP; k++) step();
      chk(tog_n == 0, "R8 accumulator cleared", tog_n, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule